// File: doc/BRIEF.md
# Data-Phase Byte Buffer and Transfer Length Unit

This block sits inside a storage bus controller and carries the bytes of programmed-I/O data phases through a 16-entry byte buffer. It keeps a signed remaining-size value whose sign tells the direction of the data phase. Host writes and reads move the buffer pointers and the size. While the controller is collecting a command, host writes go to a separate 16-byte command buffer and leave the data buffer alone.

For DMA data phases the block holds the last values written to the two count bytes. It copies them into a working 16-bit transfer counter when a command with the DMA bit is issued. When a transfer starts, it works out the effective length: the smaller of the counter (where zero stands for 65536) and the magnitude of the remaining size. During command capture the ceiling is 32 instead of the size. A DMA-done event sets terminal count, loads the interrupt code 0x10, clears the working counter and tells the surrounding controller to clear its sequence-step and flags registers.

Top module: `xfer_fifo_ctl`

## Requirements
- R1: After reset, `fifo_size`, `fifo_rdata`, `work_cnt`, `dma_mode`, `tc_flag`, `intr_code`, `cmd_len`, `overrun`, `irq_raise` and `xfer_len_vld` are all zero.
- R2: A data write (`fifo_wr` with `cap_mode` low) while `fifo_size` is not 15 stores the byte and raises `fifo_size` by one. While `fifo_size` is 15 the byte is dropped, the size is unchanged, and `overrun` is high for the following cycle.
- R3: A write with `cap_mode` high stores the byte in the command buffer at index `cmd_len` and raises `cmd_len` by one. Once `cmd_len` reaches 16, further writes are dropped. `fifo_size` is unchanged. `cmd_byte` shows command entry `cmd_idx`, and `cmd_clr` sets `cmd_len` to zero.
- R4: A read (`fifo_rd`) while `fifo_size` is above zero lowers the size by one and pulses `irq_raise` in the next cycle. It places the oldest stored byte on `fifo_rdata`, or 0 when both `bus_phase` bits are zero.
- R5: A read while `fifo_size` is zero or negative leaves `fifo_rdata`, `fifo_size` and the pointers unchanged and raises no interrupt.
- R6: Whenever `fifo_size` becomes zero, the read and write pointers both return to entry 0.
- R7: `cnt_wr` stores `cnt_wdata` as the last low byte (`cnt_hi_sel`=0) or high byte (`cnt_hi_sel`=1) and clears `tc_flag`. `cmd_issue` with `cmd_dma`=1 sets `dma_mode` and loads `work_cnt` with {high,low}. With `cmd_dma`=0 it clears `dma_mode` and keeps `work_cnt`.
- R8: One cycle after `xfer_start`, `xfer_len_vld` is high and `xfer_len` equals min(C, L). C is `work_cnt`, or 65536 when `work_cnt` is 0. L is 32 when `cap_mode` is high, and |`fifo_size`| otherwise.
- R9: One cycle after `dma_done`, `tc_flag`=1, `intr_code`=0x10, `work_cnt`=0, and `done_upd` and `irq_raise` are high. `dma_done` takes precedence over a same-cycle counter reload or `cnt_wr`.
- R10: `size_ld` loads `size_ld_val` into `fifo_size`, and any read or write in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_wr | input | 1 | Host write strobe |
| fifo_wdata | input | 8 | Host write byte |
| fifo_rd | input | 1 | Host read strobe |
| bus_phase | input | 2 | Phase bits 2:1 of controller status |
| size_ld | input | 1 | Load remaining size |
| size_ld_val | input | 18 | Signed size to load |
| cap_mode | input | 1 | Command capture active |
| cmd_clr | input | 1 | Empty the command buffer |
| cmd_idx | input | 4 | Command buffer view index |
| cnt_wr | input | 1 | Count byte write strobe |
| cnt_hi_sel | input | 1 | Selects the high count byte |
| cnt_wdata | input | 8 | Count byte value |
| cmd_issue | input | 1 | Command issued |
| cmd_dma | input | 1 | DMA bit of the issued command |
| xfer_start | input | 1 | Transfer start |
| dma_done | input | 1 | DMA phase completed |
| fifo_rdata | output | 8 | Last read byte |
| fifo_size | output | 18 | Signed remaining size |
| overrun | output | 1 | Dropped-write pulse |
| irq_raise | output | 1 | Interrupt raise pulse |
| cmd_len | output | 5 | Command bytes captured |
| cmd_byte | output | 8 | Command entry at cmd_idx |
| dma_mode | output | 1 | DMA mode selected |
| work_cnt | output | 16 | Working transfer counter |
| xfer_len | output | 17 | Effective transfer length |
| xfer_len_vld | output | 1 | xfer_len valid pulse |
| tc_flag | output | 1 | Terminal count status |
| intr_code | output | 8 | Interrupt reason code |
| done_upd | output | 1 | Clear sequence step and flags pulse |

## Verification
Every result of this block is a register, so each one is due exactly one clock edge after the stimulus that caused it. This applies to sizes, read bytes, overrun and interrupt pulses, counter reloads, the effective length and the done update. `cmd_byte` is the exception: it is a combinational view of state that was itself written one edge earlier. The bench changes inputs 1 ns after a rising edge, waits for the next rising edge, and samples 1 ns later. Each check therefore reads the cycle in which its result first appears, and single-cycle pulses are checked in that same window.

// File: rtl/xff_pkg.sv
// Shared types for the data-phase buffer block.
// Assumes byte-wide host data.
package xff_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
    localparam byte_t INTR_DONE_CODE = 8'h10;
endpackage

// File: rtl/xff_store.sv
// Data byte buffer with read/write pointers and a signed remaining size.
// Assumes at most one write and one read per cycle; a size load wins over both.
module xff_store #(
    parameter int DEPTH  = 16,
    parameter int SIZE_W = 18
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  xff_pkg::byte_t           wdata,
    input  logic                     rd,
    input  logic                     phase_ok,
    input  logic                     ld,
    input  logic signed [SIZE_W-1:0] ld_val,
    output xff_pkg::byte_t           rdata,
    output logic signed [SIZE_W-1:0] size,
    output logic                     overrun,
    output logic                     rd_hit
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic signed [SIZE_W-1:0] FULL_LVL = SIZE_W'(DEPTH - 1);

    xff_pkg::byte_t mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic wr_ok, rd_ok, wr_try;
    logic signed [SIZE_W-1:0] nxt_size;

    // Decide which accesses take effect and the next size.
    always_comb begin
        wr_try   = wr && !ld;
        wr_ok    = wr_try && (size != FULL_LVL);
        rd_ok    = rd && !ld && (size > 0);
        if (ld)
            nxt_size = ld_val;
        else
            nxt_size = size + SIZE_W'(wr_ok) - SIZE_W'(rd_ok);
    end

    // Byte storage at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[wptr] <= wdata;
    end

    // Size, pointers, read byte and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size    <= '0;
            wptr    <= '0;
            rptr    <= '0;
            rdata   <= '0;
            overrun <= 1'b0;
            rd_hit  <= 1'b0;
        end else begin
            size    <= nxt_size;
            overrun <= wr_try && !wr_ok;
            rd_hit  <= rd_ok;
            if (rd_ok)
                rdata <= phase_ok ? mem[rptr] : '0;
            if (nxt_size == '0) begin
                wptr <= '0;
                rptr <= '0;
            end else begin
                if (wr_ok) wptr <= wptr + 1'b1;
                if (rd_ok) rptr <= rptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xff_cmdcap.sv
// Command capture buffer: appends bytes until full, viewable by index.
// Assumes clear wins over a same-cycle append.
module xff_cmdcap #(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  xff_pkg::byte_t             wdata,
    input  logic                       clr,
    input  logic [$clog2(DEPTH)-1:0]   idx,
    output logic [$clog2(DEPTH):0]     len,
    output xff_pkg::byte_t             byte_o
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [IW:0] LEN_MAX = (IW+1)'(DEPTH);

    xff_pkg::byte_t mem [DEPTH];

    // Append storage.
    always_ff @(posedge clk) begin
        if (wr && !clr && len < LEN_MAX)
            mem[len[IW-1:0]] <= wdata;
    end

    // Captured length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len <= '0;
        else if (clr)
            len <= '0;
        else if (wr && len < LEN_MAX)
            len <= len + 1'b1;
    end

    // Indexed view.
    assign byte_o = mem[idx];
endmodule

// File: rtl/xff_len.sv
// Count byte holding, working counter, effective length and done update.
// Assumes SIZE_W > CNT_W so the size magnitude never overflows.
module xff_len #(
    parameter int CNT_W     = 16,
    parameter int SIZE_W    = 18,
    parameter int CAP_LIMIT = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cnt_wr,
    input  logic                     cnt_hi_sel,
    input  logic [CNT_W/2-1:0]       cnt_wdata,
    input  logic                     cmd_issue,
    input  logic                     cmd_dma,
    input  logic                     start,
    input  logic                     cap_mode,
    input  logic signed [SIZE_W-1:0] size,
    input  logic                     dma_done,
    output logic [CNT_W-1:0]         work_cnt,
    output logic                     dma_mode,
    output logic [CNT_W:0]           xfer_len,
    output logic                     len_vld,
    output logic                     tc_flag,
    output xff_pkg::byte_t           intr_code,
    output logic                     done_upd
);
    localparam int HALF = CNT_W / 2;

    logic [HALF-1:0]   lo_q, hi_q;
    logic [CNT_W:0]    eff_cnt;
    logic [SIZE_W-1:0] mag, limit, eff_ext;
    logic [CNT_W:0]    len_c;

    // Effective length: min of counter (zero means full range) and limit.
    always_comb begin
        eff_cnt = (work_cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, work_cnt};
        eff_ext = SIZE_W'(eff_cnt);
        mag     = (size < 0) ? SIZE_W'(-size) : SIZE_W'(size);
        limit   = cap_mode ? SIZE_W'(CAP_LIMIT) : mag;
        len_c   = (limit < eff_ext) ? limit[CNT_W:0] : eff_cnt;
    end

    // Count byte holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (cnt_wr) begin
            if (cnt_hi_sel) hi_q <= cnt_wdata;
            else            lo_q <= cnt_wdata;
        end
    end

    // Working counter, mode, status and length outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_cnt  <= '0;
            dma_mode  <= 1'b0;
            xfer_len  <= '0;
            len_vld   <= 1'b0;
            tc_flag   <= 1'b0;
            intr_code <= '0;
            done_upd  <= 1'b0;
        end else begin
            len_vld  <= start;
            done_upd <= dma_done;
            if (start)
                xfer_len <= len_c;
            if (cmd_issue)
                dma_mode <= cmd_dma;
            if (dma_done)
                work_cnt <= '0;
            else if (cmd_issue && cmd_dma)
                work_cnt <= {hi_q, lo_q};
            if (dma_done) begin
                tc_flag   <= 1'b1;
                intr_code <= xff_pkg::INTR_DONE_CODE;
            end else if (cnt_wr) begin
                tc_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/xfer_fifo_ctl.sv
// Top: data-phase byte buffer, command capture and transfer length unit.
// Assumes host strobes are single-cycle and already decoded.
module xfer_fifo_ctl #(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 16,
    parameter int SIZE_W    = 18,
    parameter int CNT_W     = 16,
    parameter int CAP_LIMIT = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fifo_wr,
    input  logic [7:0]                   fifo_wdata,
    input  logic                         fifo_rd,
    input  logic [2:1]                   bus_phase,
    input  logic                         size_ld,
    input  logic signed [SIZE_W-1:0]     size_ld_val,
    input  logic                         cap_mode,
    input  logic                         cmd_clr,
    input  logic [$clog2(CMD_DEPTH)-1:0] cmd_idx,
    input  logic                         cnt_wr,
    input  logic                         cnt_hi_sel,
    input  logic [CNT_W/2-1:0]           cnt_wdata,
    input  logic                         cmd_issue,
    input  logic                         cmd_dma,
    input  logic                         xfer_start,
    input  logic                         dma_done,
    output logic [7:0]                   fifo_rdata,
    output logic signed [SIZE_W-1:0]     fifo_size,
    output logic                         overrun,
    output logic                         irq_raise,
    output logic [$clog2(CMD_DEPTH):0]   cmd_len,
    output logic [7:0]                   cmd_byte,
    output logic                         dma_mode,
    output logic [CNT_W-1:0]             work_cnt,
    output logic [CNT_W:0]               xfer_len,
    output logic                         xfer_len_vld,
    output logic                         tc_flag,
    output logic [7:0]                   intr_code,
    output logic                         done_upd
);
    logic rd_hit;
    logic data_wr, cap_wr;

    // Route host writes to the data or command buffer.
    always_comb begin
        data_wr = fifo_wr && !cap_mode;
        cap_wr  = fifo_wr && cap_mode;
    end

    xff_store #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr(data_wr), .wdata(fifo_wdata), .rd(fifo_rd),
        .phase_ok(bus_phase != 2'b00),
        .ld(size_ld), .ld_val(size_ld_val),
        .rdata(fifo_rdata), .size(fifo_size),
        .overrun(overrun), .rd_hit(rd_hit)
    );

    xff_cmdcap #(.DEPTH(CMD_DEPTH)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .wr(cap_wr), .wdata(fifo_wdata), .clr(cmd_clr),
        .idx(cmd_idx), .len(cmd_len), .byte_o(cmd_byte)
    );

    xff_len #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .CAP_LIMIT(CAP_LIMIT)) u_len (
        .clk(clk), .rst_n(rst_n),
        .cnt_wr(cnt_wr), .cnt_hi_sel(cnt_hi_sel), .cnt_wdata(cnt_wdata),
        .cmd_issue(cmd_issue), .cmd_dma(cmd_dma),
        .start(xfer_start), .cap_mode(cap_mode), .size(fifo_size),
        .dma_done(dma_done),
        .work_cnt(work_cnt), .dma_mode(dma_mode),
        .xfer_len(xfer_len), .len_vld(xfer_len_vld),
        .tc_flag(tc_flag), .intr_code(intr_code), .done_upd(done_upd)
    );

    // Interrupt raise from a successful read or a completed DMA phase.
    assign irq_raise = rd_hit | done_upd;
endmodule

// File: rtl/xfer_fifo_ctl_chk.sv
// Property checker for xfer_fifo_ctl, attached by bind.
module xfer_fifo_ctl_chk #(
    parameter int SIZE_W = 18,
    parameter int CNT_W  = 16,
    parameter int DEPTH  = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     fifo_wr,
    input logic                     fifo_rd,
    input logic                     cap_mode,
    input logic                     size_ld,
    input logic signed [SIZE_W-1:0] size_ld_val,
    input logic signed [SIZE_W-1:0] fifo_size,
    input logic [7:0]               fifo_rdata,
    input logic                     overrun,
    input logic                     irq_raise,
    input logic                     cmd_issue,
    input logic                     cmd_dma,
    input logic                     dma_mode,
    input logic                     xfer_start,
    input logic                     xfer_len_vld,
    input logic [CNT_W:0]           xfer_len,
    input logic                     dma_done,
    input logic                     tc_flag,
    input logic [7:0]               intr_code,
    input logic [CNT_W-1:0]         work_cnt,
    input logic                     done_upd
);
    localparam logic signed [SIZE_W-1:0] FULL_LVL = SIZE_W'(DEPTH - 1);

    // R2
    wr_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && !cap_mode && !size_ld && fifo_size == FULL_LVL) |=> overrun);

    // R3
    cap_keeps_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr && cap_mode && !fifo_rd && !size_ld) |=> $stable(fifo_size));

    // R5
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd && fifo_size <= 0 && !fifo_wr && !size_ld && !dma_done)
        |=> ($stable(fifo_rdata) && !irq_raise));

    // R7
    pio_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_issue && !cmd_dma) |=> !dma_mode);

    // R8
    len_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (xfer_len_vld && xfer_len <= (CNT_W+1)'(1 << CNT_W)));

    // R9
    done_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> (tc_flag && intr_code == 8'h10 && work_cnt == '0
                      && done_upd && irq_raise));

    // R10
    size_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size_ld |=> (fifo_size == $past(size_ld_val)));
endmodule

bind xfer_fifo_ctl xfer_fifo_ctl_chk #(.SIZE_W(SIZE_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd),
    .cap_mode(cap_mode), .size_ld(size_ld), .size_ld_val(size_ld_val),
    .fifo_size(fifo_size), .fifo_rdata(fifo_rdata), .overrun(overrun),
    .irq_raise(irq_raise), .cmd_issue(cmd_issue), .cmd_dma(cmd_dma),
    .dma_mode(dma_mode), .xfer_start(xfer_start), .xfer_len_vld(xfer_len_vld),
    .xfer_len(xfer_len), .dma_done(dma_done), .tc_flag(tc_flag),
    .intr_code(intr_code), .work_cnt(work_cnt), .done_upd(done_upd)
);

// File: tb/xfer_fifo_ctl_bench.sv
module xfer_fifo_ctl_bench;
    logic clk = 1'b0;
    logic rst_n;
    logic fifo_wr, fifo_rd, size_ld, cap_mode, cmd_clr;
    logic cnt_wr, cnt_hi_sel, cmd_issue, cmd_dma, xfer_start, dma_done;
    logic [7:0] fifo_wdata, cnt_wdata;
    logic [2:1] bus_phase;
    logic signed [17:0] size_ld_val;
    logic [3:0] cmd_idx;
    logic [7:0] fifo_rdata, cmd_byte, intr_code;
    logic signed [17:0] fifo_size;
    logic overrun, irq_raise, dma_mode, xfer_len_vld, tc_flag, done_upd;
    logic [4:0] cmd_len;
    logic [15:0] work_cnt;
    logic [16:0] xfer_len;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    xfer_fifo_ctl u_xfer_fifo_ctl (
        .clk(clk), .rst_n(rst_n), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_rd(fifo_rd), .bus_phase(bus_phase), .size_ld(size_ld),
        .size_ld_val(size_ld_val), .cap_mode(cap_mode), .cmd_clr(cmd_clr),
        .cmd_idx(cmd_idx), .cnt_wr(cnt_wr), .cnt_hi_sel(cnt_hi_sel),
        .cnt_wdata(cnt_wdata), .cmd_issue(cmd_issue), .cmd_dma(cmd_dma),
        .xfer_start(xfer_start), .dma_done(dma_done),
        .fifo_rdata(fifo_rdata), .fifo_size(fifo_size), .overrun(overrun),
        .irq_raise(irq_raise), .cmd_len(cmd_len), .cmd_byte(cmd_byte),
        .dma_mode(dma_mode), .work_cnt(work_cnt), .xfer_len(xfer_len),
        .xfer_len_vld(xfer_len_vld), .tc_flag(tc_flag), .intr_code(intr_code),
        .done_upd(done_upd)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        fifo_wr = 1'b1; fifo_wdata = d; tick(); fifo_wr = 1'b0;
    endtask

    task automatic rd_byte();
        fifo_rd = 1'b1; tick(); fifo_rd = 1'b0;
    endtask

    task automatic load_size(input int v);
        size_ld = 1'b1; size_ld_val = 18'(v); tick(); size_ld = 1'b0;
    endtask

    task automatic set_count(input int v);
        cnt_wr = 1'b1; cnt_hi_sel = 1'b0; cnt_wdata = 8'(v); tick();
        cnt_hi_sel = 1'b1; cnt_wdata = 8'(v >> 8); tick();
        cnt_wr = 1'b0; cnt_hi_sel = 1'b0;
        cmd_issue = 1'b1; cmd_dma = 1'b1; tick();
        cmd_issue = 1'b0; cmd_dma = 1'b0;
    endtask

    function automatic int exp_len(input int cnt, input int sz, input bit cap);
        int e, m;
        e = (cnt == 0) ? 65536 : cnt;
        m = cap ? 32 : ((sz < 0) ? -sz : sz);
        return (m < e) ? m : e;
    endfunction

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cnts[9] = '{0, 1, 31, 32, 33, 255, 256, 16'h1234, 16'hFFFF};
        int sizes[6] = '{0, 5, -40, 100000, -70000, 65536};
        rst_n = 1'b0;
        fifo_wr = 0; fifo_rd = 0; size_ld = 0; cap_mode = 0; cmd_clr = 0;
        cnt_wr = 0; cnt_hi_sel = 0; cmd_issue = 0; cmd_dma = 0;
        xfer_start = 0; dma_done = 0; fifo_wdata = 0; cnt_wdata = 0;
        bus_phase = 2'b01; size_ld_val = 0; cmd_idx = 0;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 size", fifo_size, 0);
        chk("R1 rdata", fifo_rdata, 0);
        chk("R1 work_cnt", work_cnt, 0);
        chk("R1 dma_mode", dma_mode, 0);
        chk("R1 tc_flag", tc_flag, 0);
        chk("R1 intr_code", intr_code, 0);
        chk("R1 cmd_len", cmd_len, 0);
        chk("R1 pulses", {overrun, irq_raise, xfer_len_vld}, 0);

        // R2 and R4: sweep fill levels, read back in order
        for (int n = 1; n <= 15; n++) begin
            for (int i = 0; i < n; i++) begin
                wr_byte(8'(n * 16 + i * 7));
                chk("R2 size after write", fifo_size, i + 1);
            end
            for (int i = 0; i < n; i++) begin
                rd_byte();
                chk("R4 read byte", fifo_rdata, (n * 16 + i * 7) & 8'hFF);
                chk("R4 size after read", fifo_size, n - 1 - i);
                chk("R4 irq pulse", irq_raise, 1);
            end
        end

        // R2 overrun at 15 stored bytes
        for (int i = 0; i < 15; i++) wr_byte(8'(8'hC0 + i));
        chk("R2 no overrun below full", overrun, 0);
        wr_byte(8'hEE);
        chk("R2 overrun pulse", overrun, 1);
        chk("R2 size held at 15", fifo_size, 15);
        tick();
        chk("R2 overrun one cycle", overrun, 0);
        for (int i = 0; i < 15; i++) begin
            rd_byte();
            chk("R2 stored bytes intact", fifo_rdata, 8'hC0 + i);
        end
        // R5 read at zero size
        rd_byte();
        chk("R5 rdata held", fifo_rdata, 8'hCE);
        chk("R5 size stays 0", fifo_size, 0);
        chk("R5 no irq", irq_raise, 0);

        // R4 phase bits zero gives 0
        wr_byte(8'h77); wr_byte(8'h78);
        bus_phase = 2'b00;
        rd_byte();
        chk("R4 phase zero byte", fifo_rdata, 0);
        chk("R4 phase zero size", fifo_size, 1);
        bus_phase = 2'b10;
        rd_byte();
        chk("R4 phase 2 byte", fifo_rdata, 8'h78);

        // R6 pointer return to 0 on empty
        wr_byte(8'h5A); wr_byte(8'h6B);
        rd_byte(); rd_byte();
        load_size(1);
        rd_byte();
        chk("R6 read from entry 0", fifo_rdata, 8'h5A);

        // R5 negative size
        load_size(-3);
        rd_byte();
        chk("R5 negative size kept", fifo_size, -3);
        chk("R5 negative no irq", irq_raise, 0);
        chk("R5 negative rdata held", fifo_rdata, 8'h5A);

        // R10 load wins over write and read
        load_size(2);
        fifo_wr = 1'b1; fifo_rd = 1'b1; fifo_wdata = 8'h11;
        size_ld = 1'b1; size_ld_val = 18'sd9; tick();
        fifo_wr = 1'b0; fifo_rd = 1'b0; size_ld = 1'b0;
        chk("R10 size loaded", fifo_size, 9);
        chk("R10 read ignored", irq_raise, 0);
        load_size(0);

        // R3 command capture
        cmd_clr = 1'b1; tick(); cmd_clr = 1'b0;
        cap_mode = 1'b1;
        for (int i = 0; i < 18; i++) begin
            wr_byte(8'(8'h30 + i));
            chk("R3 cmd_len", cmd_len, (i + 1 > 16) ? 16 : i + 1);
            chk("R3 size untouched", fifo_size, 0);
        end
        for (int i = 0; i < 16; i++) begin
            cmd_idx = 4'(i); #1;
            chk("R3 cmd byte", cmd_byte, 8'h30 + i);
        end
        cmd_clr = 1'b1; tick(); cmd_clr = 1'b0;
        chk("R3 clear", cmd_len, 0);
        cap_mode = 1'b0;

        // R7 count reload and mode
        set_count(16'hBEEF);
        chk("R7 work_cnt reload", work_cnt, 16'hBEEF);
        chk("R7 dma_mode set", dma_mode, 1);
        cnt_wr = 1'b1; cnt_wdata = 8'h01; tick(); cnt_wr = 1'b0;
        cmd_issue = 1'b1; cmd_dma = 1'b0; tick(); cmd_issue = 1'b0;
        chk("R7 dma_mode cleared", dma_mode, 0);
        chk("R7 work_cnt kept", work_cnt, 16'hBEEF);

        // R9 done, and precedence over reload
        dma_done = 1'b1; cmd_issue = 1'b1; cmd_dma = 1'b1; cnt_wr = 1'b1;
        tick();
        dma_done = 1'b0; cmd_issue = 1'b0; cmd_dma = 1'b0; cnt_wr = 1'b0;
        chk("R9 tc_flag", tc_flag, 1);
        chk("R9 intr_code", intr_code, 8'h10);
        chk("R9 work_cnt zero", work_cnt, 0);
        chk("R9 done_upd", done_upd, 1);
        chk("R9 irq", irq_raise, 1);
        tick();
        chk("R9 pulse ends", {done_upd, irq_raise}, 0);
        cnt_wr = 1'b1; cnt_wdata = 8'h00; tick(); cnt_wr = 1'b0;
        chk("R7 count write clears tc", tc_flag, 0);

        // R8 effective length sweep
        foreach (cnts[ci]) begin
            foreach (sizes[si]) begin
                for (int cp = 0; cp < 2; cp++) begin
                    set_count(cnts[ci]);
                    load_size(sizes[si]);
                    cap_mode = cp[0];
                    xfer_start = 1'b1; tick(); xfer_start = 1'b0;
                    cap_mode = 1'b0;
                    chk("R8 valid", xfer_len_vld, 1);
                    chk("R8 length", xfer_len, exp_len(cnts[ci], sizes[si], cp[0]));
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule